// File: doc/BRIEF.md
# External Interrupt Edge/Level Detector

This block looks after eight external pins. Each pin can act as an interrupt input or as a general-purpose output. For an input pin, the block brings the pin into the clock domain through two flops and then watches it for one configured condition: the pin being low, a rising edge, a falling edge, or either edge. It presents one interrupt request per line to a downstream interrupt controller.

Edge events are held in flag bits until software clears them by writing 1. Level-mode lines report the current pin level and hold no state.

Software sees four 16-bit registers through a single write port and a combinational read port:

- **Trigger configuration:** two bits per line.
- **Direction.**
- **Line state:** a write sets the output data; a read returns the value of the pin.
- **Event flags.**

Top module: `extint_detector`

## Requirements
- R1: After reset the trigger register reads 0 (every line low-level mode), the direction register reads 0 (every line an input), the output data and all event flags are 0, irq is 0 and pin_oe is 0.
- R2: Every input pin passes through a two-flop synchroniser. A pin change made before clock edge k shows on a level-mode irq after edge k+1, and sets an edge flag at edge k+2.
- R3: Line n takes its 2-bit trigger code from bits [2n+1:2n] of register 0. Code 0 is low-level mode: irq[n] is 1 exactly while the synchronised pin is 0. There is no active-high level mode.
- R4: Code 1 latches the line's flag on a 0-to-1 change of the synchronised pin.
- R5: Code 2 latches the line's flag on a 1-to-0 change of the synchronised pin.
- R6: Code 3 latches the line's flag on a change of the synchronised pin in either direction.
- R7: In the edge modes, irq[n] equals the latched flag. The flag stays set until a write to register 3 has bit n at 1. A 0 in that bit of the write leaves the flag unchanged.
- R8: If a qualifying edge and a write-1 clear of the same line fall in the same cycle, the flag stays set.
- R9: Bit n of register 1 at 1 makes line n an output: pin_oe[n] is 1, and irq[n] and the flag of line n stay 0 whatever the pin does.
- R10: A write to register 2 sets the output data, and pin_out shows it from the next cycle on.
- R11: rd_data follows addr without a clock, with the upper 8 bits 0 for registers 1 to 3:
  - addr 0 returns the trigger codes.
  - addr 1 returns the direction bits.
  - addr 2 returns, per line, the output data for output lines and the synchronised pin for input lines.
  - addr 3 returns the per-line request, which is the same value as irq.
- R12: A latched edge flag is discarded as soon as its line is in level mode or set as an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 8 | Asynchronous pin values |
| pin_out | output | 8 | Output data driven to the pins |
| pin_oe | output | 8 | Output enable per pin (1 = drive) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 trigger, 1 direction, 2 line state, 3 flags |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the selected register |
| irq | output | 8 | Interrupt request per line |

## Verification
The bench first runs all lines in low-level mode under pseudo-random pin activity, which isolates the synchroniser latency and the polarity of the level path. It then sets the four trigger codes side by side on neighbouring lines and drives the same random activity, so that a swapped code, a wrong bit field or a missing edge direction shows up as one line disagreeing with the model. Clears are driven with zero masks, with partial masks, and on the exact cycle an edge is detected, which separates write-1-to-clear from plain overwrite and checks the priority of set over clear. A final mix makes random writes to every register while the pins toggle, which covers direction changes and mode changes that must drop latched flags.

// File: rtl/extint_pkg.sv
package extint_pkg;

    // Register select values seen on addr
    typedef enum logic [1:0] {
        REG_TRIG  = 2'd0,
        REG_DIR   = 2'd1,
        REG_STATE = 2'd2,
        REG_FLAG  = 2'd3
    } reg_sel_e;

    // Per-line trigger codes
    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_RISE = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_BOTH = 2'd3
    } trig_e;

    localparam int CODE_W = 2;

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] last
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
        logic [WIDTH-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = raw;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    // Reset to the idle (high) level so that no low-level request or
    // edge appears before the real pin value has propagated.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: '1, s2: '1, prev: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign cur  = st_q.s2;
    assign last = st_q.prev;
endmodule

// File: rtl/extint_line.sv
module extint_line
    import extint_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] mode,
    input  logic              is_out,
    input  logic              cur,
    input  logic              last,
    input  logic              clr,
    output logic              req
);
    logic edge_d, edge_q;
    logic hit;

    always_comb begin
        unique case (mode)
            TRIG_RISE: hit = cur & ~last;
            TRIG_FALL: hit = ~cur & last;
            TRIG_BOTH: hit = cur ^ last;
            default:   hit = 1'b0;
        endcase
        // Set wins over clear; leaving edge input mode drops the flag
        if (is_out || mode == TRIG_LOW) begin
            edge_d = 1'b0;
        end else begin
            edge_d = hit | (edge_q & ~clr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= 1'b0;
        end else begin
            edge_q <= edge_d;
        end
    end

    always_comb begin
        if (is_out) begin
            req = 1'b0;
        end else if (mode == TRIG_LOW) begin
            req = ~cur;
        end else begin
            req = edge_q;
        end
    end
endmodule

// File: rtl/extint_detector.sv
module extint_detector
    import extint_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int REG_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0] pin_out,
    output logic [NUM_LINES-1:0] pin_oe,
    input  logic                 wr_en,
    input  logic [1:0]           addr,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    output logic [NUM_LINES-1:0] irq
);
    localparam int PAD_W = REG_W - NUM_LINES;

    typedef struct packed {
        logic [REG_W-1:0]     trig;
        logic [NUM_LINES-1:0] dir;
        logic [NUM_LINES-1:0] dout;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NUM_LINES-1:0] sync_cur, sync_last;
    logic [NUM_LINES-1:0] clr_vec;
    logic [NUM_LINES-1:0] line_state;
    logic [REG_W-1:0]     trig_q;

    assign trig_q = regs_q.trig;

    extint_sync #(.WIDTH(NUM_LINES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (pin_in),
        .cur  (sync_cur),
        .last (sync_last)
    );

    assign clr_vec = (wr_en && addr == REG_FLAG) ? wr_data[NUM_LINES-1:0] : '0;

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        extint_line line_i (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (regs_q.trig[CODE_W*n +: CODE_W]),
            .is_out(regs_q.dir[n]),
            .cur   (sync_cur[n]),
            .last  (sync_last[n]),
            .clr   (clr_vec[n]),
            .req   (irq[n])
        );
    end

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (addr)
                REG_TRIG:  regs_d.trig = wr_data;
                REG_DIR:   regs_d.dir  = wr_data[NUM_LINES-1:0];
                REG_STATE: regs_d.dout = wr_data[NUM_LINES-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign line_state = (regs_q.dir & regs_q.dout) | (~regs_q.dir & sync_cur);

    always_comb begin
        unique case (addr)
            REG_TRIG:  rd_data = regs_q.trig;
            REG_DIR:   rd_data = {{PAD_W{1'b0}}, regs_q.dir};
            REG_STATE: rd_data = {{PAD_W{1'b0}}, line_state};
            default:   rd_data = {{PAD_W{1'b0}}, irq};
        endcase
    end

    assign pin_out = regs_q.dout;
    assign pin_oe  = regs_q.dir;
endmodule

// File: rtl/extint_detector_chk.sv
module extint_detector_chk #(
    parameter int NUM_LINES = 8,
    parameter int REG_W     = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [1:0]           addr,
    input logic [REG_W-1:0]     wr_data,
    input logic [NUM_LINES-1:0] irq,
    input logic [NUM_LINES-1:0] pin_oe,
    input logic [NUM_LINES-1:0] pin_out,
    input logic [REG_W-1:0]     trig
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq == '0 && pin_oe == '0 && pin_out == '0)); // R1

    AST_OE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1) |=> pin_oe == $past(wr_data[NUM_LINES-1:0])); // R9

    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & pin_oe) == '0); // R9

    AST_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd2) |=> pin_out == $past(wr_data[NUM_LINES-1:0])); // R10

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_hold
        AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[n] && trig[2*n +: 2] != 2'd0 && !pin_oe[n] &&
             !(wr_en && (addr == 2'd0 || addr == 2'd1 ||
                         (addr == 2'd3 && wr_data[n]))))
            |=> irq[n]); // R7
    end
endmodule

bind extint_detector extint_detector_chk #(
    .NUM_LINES(NUM_LINES),
    .REG_W    (REG_W)
) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wr_data(wr_data),
    .irq    (irq),
    .pin_oe (pin_oe),
    .pin_out(pin_out),
    .trig   (trig_q)
);

// File: tb/extint_detector_tb_top.sv
`timescale 1ns/1ps
module extint_detector_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_in = 8'hFF;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic [7:0]  pin_out, pin_oe, irq;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    string phase = "R1";

    // behavioural model state
    int m_s1[8], m_s2[8], m_prev[8], m_ef[8];
    int m_trig, m_dir, m_data;

    always #2.5 clk = ~clk;

    extint_detector dut_i (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq)
    );

    function automatic int mode_of(int n);
        return (m_trig >> (2 * n)) & 3;
    endfunction

    function automatic logic [7:0] exp_irq();
        logic [7:0] r = '0;
        for (int n = 0; n < 8; n++) begin
            if (((m_dir >> n) & 1) == 1) r[n] = 1'b0;
            else if (mode_of(n) == 0) r[n] = (m_s2[n] == 0);
            else r[n] = (m_ef[n] != 0);
        end
        return r;
    endfunction

    function automatic logic [15:0] exp_rd();
        logic [7:0] st = '0;
        case (addr)
            2'd0: return m_trig[15:0];
            2'd1: return {8'h00, m_dir[7:0]};
            2'd2: begin
                for (int n = 0; n < 8; n++)
                    st[n] = (((m_dir >> n) & 1) == 1) ? m_data[n] : (m_s2[n] != 0);
                return {8'h00, st};
            end
            default: return {8'h00, exp_irq()};
        endcase
    endfunction

    task automatic model_step();
        int nef[8];
        for (int n = 0; n < 8; n++) begin
            int md = mode_of(n);
            int cur = m_s2[n];
            int lst = m_prev[n];
            bit hit, clr;
            clr = wr_en && addr == 2'd3 && wr_data[n];
            hit = (md == 1 && cur == 1 && lst == 0) ||
                  (md == 2 && cur == 0 && lst == 1) ||
                  (md == 3 && cur != lst);
            if (((m_dir >> n) & 1) == 1 || md == 0) nef[n] = 0;
            else nef[n] = (hit || (m_ef[n] != 0 && !clr)) ? 1 : 0;
        end
        for (int n = 0; n < 8; n++) begin
            m_ef[n]   = nef[n];
            m_prev[n] = m_s2[n];
            m_s2[n]   = m_s1[n];
            m_s1[n]   = pin_in[n];
        end
        if (wr_en) begin
            case (addr)
                2'd0: m_trig = wr_data;
                2'd1: m_dir  = wr_data[7:0];
                2'd2: m_data = wr_data[7:0];
                default: ;
            endcase
        end
        if (!rst_n) begin
            for (int n = 0; n < 8; n++) begin
                m_s1[n] = 1; m_s2[n] = 1; m_prev[n] = 1; m_ef[n] = 0;
            end
            m_trig = 0; m_dir = 0; m_data = 0;
        end
    endtask

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk({8'h0, irq}, {8'h0, exp_irq()}, "irq");
        chk({8'h0, pin_oe}, {8'h0, m_dir[7:0]}, "pin_oe");
        chk({8'h0, pin_out}, {8'h0, m_data[7:0]}, "pin_out");
        chk(rd_data, exp_rd(), "rd_data");
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all();
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        cycle();
        wr_en = 1'b0;
    endtask

    task automatic rand_pins(input int cycles, input bit flag_writes, input bit any_writes);
        for (int i = 0; i < cycles; i++) begin
            pin_in = 8'($urandom);
            addr = 2'($urandom);
            wr_en = 1'b0;
            if (flag_writes && ($urandom % 4) == 0) begin
                wr_en = 1'b1; addr = 2'd3; wr_data = 16'($urandom);
            end
            if (any_writes && ($urandom % 6) == 0) begin
                wr_en = 1'b1; addr = 2'($urandom); wr_data = 16'($urandom);
            end
            cycle();
            wr_en = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(7));
        // R1: reset state
        phase = "R1";
        repeat (3) cycle();
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) begin addr = 2'(a); cycle(); end

        // R2 / R3: level mode with latency
        phase = "R2";
        addr = 2'd3;
        pin_in = 8'hFE; cycle();
        chk({8'h0, irq}, 16'h0, "R2 one edge after change");
        cycle();
        chk({8'h0, irq}, 16'h1, "R2 two edges after change");
        phase = "R3";
        rand_pins(40, 0, 0);

        // R11: mixed codes (line n code n%4), R4 R5 R6 under random pins
        phase = "R11";
        pin_in = 8'hFF;
        wr(2'd0, 16'hE4E4);
        repeat (4) cycle();
        wr(2'd3, 16'h00FF);
        phase = "R4 R5 R6";
        rand_pins(80, 0, 0);

        // R7: zero-mask write keeps flags, partial mask clears some
        phase = "R7";
        pin_in = 8'h00; repeat (3) cycle();
        pin_in = 8'hFF; repeat (3) cycle();
        wr(2'd3, 16'h0000);
        addr = 2'd3; cycle();
        wr(2'd3, 16'h000A);
        addr = 2'd3; cycle();
        wr(2'd3, 16'hFFFF);
        addr = 2'd3; cycle();

        // R8: clear on the very cycle the rising edge of line 1 is caught
        phase = "R8";
        pin_in = 8'hFD; repeat (3) cycle();
        wr(2'd3, 16'h00FF);
        pin_in = 8'hFF; cycle(); cycle();
        wr(2'd3, 16'h0002);
        chk({15'h0, irq[1]}, 16'h1, "R8 flag survives same-cycle clear");
        phase = "R8 random";
        rand_pins(80, 1, 0);

        // R9 R10: outputs
        phase = "R9 R10";
        wr(2'd1, 16'h000F);
        wr(2'd2, 16'h00A5);
        rand_pins(40, 0, 0);
        wr(2'd2, 16'h005A);
        rand_pins(20, 1, 0);

        // R12: flags dropped on leaving edge mode or turning into output
        phase = "R12";
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'hFFFF);
        pin_in = 8'h00; repeat (3) cycle();
        pin_in = 8'hFF; repeat (3) cycle();
        wr(2'd1, 16'h00F0);
        addr = 2'd3; cycle();
        wr(2'd0, 16'h0000);
        addr = 2'd3; cycle();

        // mix of all registers
        phase = "R11 mix";
        rand_pins(300, 1, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule